// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the word address for one port of a synchronous memory array. In a given cycle the address comes from one of two places: the external address bus, or an internal counter. Three active-low strobes, all sampled on the rising clock edge, control the counter. A clear strobe forces it to zero. A load strobe captures the external address. A count strobe advances it by one word. When none of the strobes is active, the counter keeps its value.

The strobes follow a fixed priority: clear, then load, then count. A lower-priority strobe has no effect in any cycle where a higher one is low. The counter spans the whole array, so an increment from the top address returns to zero.

The counter has no asynchronous reset. A system brings it to a known state by pulsing the clear strobe. The block has no data path of its own, so every pin is a plain level-sampled control or address bus and no flow control is involved.

Top module: `burst_addr_gen`

## Requirements
- R1: In a cycle where `load_n` is low and `cnt_rst_n` is high, `mem_addr` equals `ext_addr` in that same cycle, with no register delay.
- R2: After a rising edge at which `load_n` was low and `cnt_rst_n` was high, the counter holds the `ext_addr` value that was sampled at that edge.
- R3: After a rising edge at which `cnt_en_n` was low and both `load_n` and `cnt_rst_n` were high, the counter equals its previous value plus one.
- R4: An increment from the all-ones address gives zero, modulo 2^ADDR_W.
- R5: When `load_n` is low, `cnt_en_n` has no effect. The counter takes the loaded address, not that address plus one.
- R6: When `cnt_rst_n` is low, neither `load_n` nor `cnt_en_n` has any effect on the counter.
- R7: In a cycle where `cnt_rst_n` is low, `mem_addr` is zero in that cycle and the counter is zero after the edge, whatever the other inputs are.
- R8: When all three strobes are high, the counter keeps its value across the edge.
- R9: In a cycle where `load_n` and `cnt_rst_n` are both high, `mem_addr` shows the counter and does not depend on `ext_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low strobe that loads the counter from `ext_addr` |
| cnt_en_n | input | 1 | Active-low strobe that advances the counter by one |
| cnt_rst_n | input | 1 | Active-low strobe that clears the counter; highest priority |
| ext_addr | input | ADDR_W | Externally supplied word address |
| mem_addr | output | ADDR_W | Address the memory uses in the current cycle |

## Verification
All three strobes can be low in the same cycle, and the interesting cases are the ones where clear and load, or load and count, are asserted together. The bench reaches these collisions by first loading a known counter value, then applying each of the eight strobe combinations with a different external address. The expected result comes from the priority rule alone. Each outcome is judged twice: once on `mem_addr` in the colliding cycle, and once on the counter value seen in the following idle cycle, while the external bus carries an unrelated value.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Counter operation selected for the current cycle, after priority.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INCR  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } burst_op_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic      load_n,
  input  logic      cnt_en_n,
  input  logic      cnt_rst_n,
  output burst_op_e op
);

  // Clear wins over load, load wins over increment.
  always_comb begin
    if (!cnt_rst_n)     op = OP_CLEAR;
    else if (!load_n)   op = OP_LOAD;
    else if (!cnt_en_n) op = OP_INCR;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  burst_op_e           op,
  input  logic [ADDR_W-1:0]   cnt_q,
  input  logic [ADDR_W-1:0]   ext_addr,
  output logic [ADDR_W-1:0]   cnt_d
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  // Wraps naturally at 2^ADDR_W because the sum is truncated.
  logic [ADDR_W-1:0] incr;
  assign incr = cnt_q + STEP;

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = ext_addr;
      OP_INCR:  cnt_d = incr;
      default:  cnt_d = cnt_q;
    endcase
  end

endmodule

// File: rtl/burst_cnt_reg.sv
module burst_cnt_reg #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] cnt_d,
  input  logic              load_n,
  input  logic              cnt_en_n,
  input  logic              cnt_rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cnt_q
);

  always_ff @(posedge clk) cnt_q <= cnt_d;

  // Checker state: the counter is meaningful only after a first clear.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!cnt_rst_n) primed <= 1'b1;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!primed)
    !cnt_rst_n |=> cnt_q == '0);

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!primed)
    (cnt_rst_n && !load_n) |=> cnt_q == $past(ext_addr));

  assert_step_R3: assert property (@(posedge clk) disable iff (!primed)
    (cnt_rst_n && load_n && !cnt_en_n) |=> cnt_q == ADDR_W'($past(cnt_q) + 1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!primed)
    (cnt_rst_n && load_n && cnt_en_n) |=> $stable(cnt_q));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              load_n,
  input  logic              cnt_en_n,
  input  logic              cnt_rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] mem_addr
);

  burst_op_e         op;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;

  burst_op_decode u_decode (
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_rst_n (cnt_rst_n),
    .op        (op)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .op       (op),
    .cnt_q    (cnt_q),
    .ext_addr (ext_addr),
    .cnt_d    (cnt_d)
  );

  burst_cnt_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk       (clk),
    .cnt_d     (cnt_d),
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_rst_n (cnt_rst_n),
    .ext_addr  (ext_addr),
    .cnt_q     (cnt_q)
  );

  // The access address bypasses the register in load and clear cycles.
  always_comb begin
    unique case (op)
      OP_CLEAR: mem_addr = '0;
      OP_LOAD:  mem_addr = ext_addr;
      default:  mem_addr = cnt_q;
    endcase
  end

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en_n = 1'b1;
  logic         cnt_rst_n = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic [W-1:0] mem_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_dut (
    .clk       (clk),
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_rst_n (cnt_rst_n),
    .ext_addr  (ext_addr),
    .mem_addr  (mem_addr)
  );

  task automatic check(input logic [W-1:0] act, input int exp, input string req);
    n_vec++;
    if (act !== W'(exp)) begin
      n_bad++;
      $display("FAIL %s: mem_addr=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // Reset state: clear with load and count also low (R7, R6).
    @(negedge clk);
    cnt_rst_n = 1'b0; load_n = 1'b0; cnt_en_n = 1'b0; ext_addr = W'(9);
    #1 check(mem_addr, 0, "R7 clear-cycle address");
    @(negedge clk);
    cnt_rst_n = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1; ext_addr = W'(5);
    #1 check(mem_addr, 0, "R6 R7 counter after clear");

    for (int start = 0; start < N; start++) begin
      for (int combo = 0; combo < 8; combo++) begin
        for (int e = 0; e < N; e++) begin
          int exp_now;
          int exp_next;
          string tag;
          // Preload the counter with start (R2).
          @(negedge clk);
          load_n = 1'b0; cnt_en_n = 1'b1; cnt_rst_n = 1'b1; ext_addr = W'(start);
          #1 check(mem_addr, start, "R1 load-cycle address");
          // Apply the strobe combination: bit2=rst_n, bit1=load_n, bit0=en_n.
          @(negedge clk);
          cnt_rst_n = combo[2]; load_n = combo[1]; cnt_en_n = combo[0];
          ext_addr = W'(e);
          if (!combo[2]) begin
            exp_now = 0; exp_next = 0; tag = "R6 R7 clear priority";
          end else if (!combo[1]) begin
            exp_now = e; exp_next = e;
            tag = combo[0] ? "R1 R2 load" : "R5 load over count";
          end else if (!combo[0]) begin
            exp_now = start; exp_next = (start + 1) % N;
            tag = (start == N-1) ? "R4 wrap" : "R3 R9 increment";
          end else begin
            exp_now = start; exp_next = start; tag = "R8 R9 hold";
          end
          #1 check(mem_addr, exp_now, tag);
          // Idle cycle with an unrelated bus value shows the counter (R9).
          @(negedge clk);
          cnt_rst_n = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1;
          ext_addr = ~W'(exp_next);
          #1 check(mem_addr, exp_next, tag);
        end
      end
    end

    // Long run of increments across the wrap point (R3, R4).
    @(negedge clk);
    load_n = 1'b0; ext_addr = W'(N - 3);
    @(negedge clk);
    load_n = 1'b1; cnt_en_n = 1'b0;
    for (int k = 0; k < 2 * N; k++) begin
      #1 check(mem_addr, (N - 3 + k) % N, "R3 R4 streaming count");
      @(negedge clk);
    end
    cnt_en_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule